// File: doc/BRIEF.md
# Three-Group Conversion Scheduler

This block decides which analog channel a shared converter works on next. It serves three conversion groups. Group 0 and group 1 are general groups. Group 2 is the event group. Each group has its own channel bitmask, sample-time field, continuous-mode bit and trigger settings. When a group is started, the block goes through the group's selected channels one at a time, from the lowest channel number upward. For each channel it holds a sample window of a programmed length. It then pulses a convert strobe and waits for the converter to answer with a done pulse.

A general group in software mode starts when a nonzero mask is written to it. Any group in hardware mode starts on an edge of one of eight event inputs. A 3-bit source field picks the input and a polarity bit picks the edge. Started groups wait in a queue and are served in the order their triggers arrived. A running group is never interrupted. A continuous group starts a new pass after each finished pass. If another group is waiting, it first goes to the back of the queue. Group 1 is forced to single-sequence mode when all three groups ask for continuous mode. The block reports the active group and channel, a busy flag per group, and an end-of-sequence pulse per group.

Top module: `adc_seq_sched`

## Requirements
- R1: For each channel the `sampling` output stays high for exactly S+2 clock cycles, where S is the group's 12-bit field in `samp_time` (group g at bits [12g+11:12g]). `conv_start` then pulses high for one cycle, in the cycle right after the window.
- R2: Within a pass, the selected channels are converted in ascending channel order, starting at the lowest set bit of the mask. A new `conv_start` is never issued while an earlier one has not yet been answered by `conv_done`.
- R3: A general group whose `hw_mode` bit is 0 is started by a `sel_wr` pulse that carries a nonzero `sel_mask`. A write of an all-zero mask starts nothing.
- R4: Pending groups are served in the order their triggers were accepted. Triggers accepted in the same cycle are queued in ascending group index order.
- R5: While `enable` is low, triggers are ignored and no sequence begins. A trigger dropped this way stays lost after `enable` returns high.
- R6: When all three `cont_mode` bits are set, group 1 runs as a single sequence.
- R7: If a group's `cont_mode` bit is cleared while the group is running continuously, the group finishes the channels of its current pass and then stops.
- R8: The event group (group 2) is started only by a hardware edge, never by a mask write. Its input is `evt_in` bit `trig_src[8:6]`. The edge is falling when `trig_pol[2]` is 0 and rising when it is 1. An edge of the other polarity, or on any other input bit, has no effect.
- R9: A general group with its `hw_mode` bit set ignores mask writes as start requests. It starts on the selected edge of `evt_in` bit `trig_src[3g+2:3g]`, using polarity `trig_pol[g]`.
- R10: A single-sequence group clears its `busy` bit and pulses its `seq_end` bit for one cycle after the done of its last channel. A continuous group reloads its mask and starts again from its lowest channel.
- R11: A trigger for a group that is already pending or running is ignored, and no extra pass runs because of it.
- R12: A running group keeps the converter until the end of its sequence or pass. At the end of a pass, a continuous group re-queues itself behind any waiting group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable for triggers and sequence starts |
| sel_wr | input | 3 | Per-group mask write strobe |
| sel_mask | input | 16 | Channel mask written by `sel_wr` |
| cont_mode | input | 3 | Per-group continuous-mode bit |
| hw_mode | input | 2 | Hardware-trigger select for groups 0 and 1 |
| trig_src | input | 9 | 3-bit event source per group |
| trig_pol | input | 3 | Edge polarity per group (0 falling, 1 rising) |
| samp_time | input | 36 | 12-bit sample field per group |
| evt_in | input | 8 | Hardware event inputs |
| conv_done | input | 1 | Converter finished the current channel |
| conv_start | output | 1 | One-cycle convert strobe |
| sampling | output | 1 | Sample window active |
| act_valid | output | 1 | A group holds the converter |
| act_grp | output | 2 | Active group index |
| act_ch | output | 4 | Active channel number |
| busy | output | 3 | Group pending or running |
| seq_end | output | 3 | One-cycle end-of-sequence pulse per group |

## Verification
The properties check, on every cycle, the rules that hold no matter what is running. The convert strobe lasts one cycle and directly follows a sample window. No second strobe is issued before a done. The channel and group stay fixed through a window. The active group is never switched without a done. The active group is always flagged busy. An end-of-sequence pulse always goes with a cleared busy bit. Only the bench scenarios can show the sequence-level results: the exact window length, the ascending channel order, the service order across groups, the triggers that are dropped, the forced single mode, the graceful stop and the yielding of a continuous group.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NUM_GRP = 3;
    localparam int GRP_W   = 2;
    localparam int EVT_GRP = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic [SRC_W-1:0]   src,
    input  logic               pol,
    output logic               hit
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = evt_in[src];
        hit   = pol ? (lvl_d && !lvl_q) : (!lvl_d && lvl_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/adc_arrival_queue.sv
module adc_arrival_queue #(
    parameter int DEPTH = 3,
    parameter int ID_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             rq_valid,
    input  logic [ID_W-1:0]  rq_id,
    input  logic [DEPTH-1:0] push_vec,
    output logic             head_valid,
    output logic [ID_W-1:0]  head_id
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0] slot;
        logic [CNT_W-1:0]           count;
    } q_s;

    q_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop && st_d.count != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) st_d.slot[i] = st_d.slot[i+1];
            st_d.count = st_d.count - CNT_W'(1);
        end
        if (rq_valid && st_d.count < CNT_W'(DEPTH)) begin
            st_d.slot[st_d.count[IDX_W-1:0]] = rq_id;
            st_d.count = st_d.count + CNT_W'(1);
        end
        for (int g = 0; g < DEPTH; g++) begin
            if (push_vec[g] && st_d.count < CNT_W'(DEPTH)) begin
                st_d.slot[st_d.count[IDX_W-1:0]] = ID_W'(g);
                st_d.count = st_d.count + CNT_W'(1);
            end
        end
        head_valid = (st_q.count != '0);
        head_id    = st_q.slot[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_seq_sched.sv
module adc_seq_sched
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int SAMP_W  = 12,
    parameter int NUM_SRC = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  enable,
    input  logic [NUM_GRP-1:0]                    sel_wr,
    input  logic [NUM_CH-1:0]                     sel_mask,
    input  logic [NUM_GRP-1:0]                    cont_mode,
    input  logic [NUM_GRP-2:0]                    hw_mode,
    input  logic [NUM_GRP*$clog2(NUM_SRC)-1:0]    trig_src,
    input  logic [NUM_GRP-1:0]                    trig_pol,
    input  logic [NUM_GRP*SAMP_W-1:0]             samp_time,
    input  logic [NUM_SRC-1:0]                    evt_in,
    input  logic                                  conv_done,
    output logic                                  conv_start,
    output logic                                  sampling,
    output logic                                  act_valid,
    output logic [GRP_W-1:0]                      act_grp,
    output logic [$clog2(NUM_CH)-1:0]             act_ch,
    output logic [NUM_GRP-1:0]                    busy,
    output logic [NUM_GRP-1:0]                    seq_end
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int CNT_W = SAMP_W + 1;

    typedef struct packed {
        seq_st_e                        st;
        logic [GRP_W-1:0]               grp;
        logic [CH_W-1:0]                ch;
        logic [NUM_CH-1:0]              rem;
        logic [CNT_W-1:0]               cnt;
        logic                           cstart;
        logic [NUM_GRP-1:0]             busy;
        logic [NUM_GRP-1:0]             send;
        logic [NUM_GRP-1:0][NUM_CH-1:0] mask;
    } seq_s;

    seq_s s_d, s_q;

    logic [NUM_GRP-1:0] edge_hit;
    logic [NUM_GRP-1:0] hw_eff;
    logic [NUM_GRP-1:0] cont_eff;
    logic [NUM_GRP-1:0] accept;
    logic               q_pop, q_rq;
    logic               head_valid;
    logic [GRP_W-1:0]   head_id;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_edge
        adc_trig_edge #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_in (evt_in),
            .src    (trig_src[g*SRC_W +: SRC_W]),
            .pol    (trig_pol[g]),
            .hit    (edge_hit[g])
        );
    end

    adc_arrival_queue #(.DEPTH(NUM_GRP), .ID_W(GRP_W)) i_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (q_pop),
        .rq_valid   (q_rq),
        .rq_id      (s_q.grp),
        .push_vec   (accept),
        .head_valid (head_valid),
        .head_id    (head_id)
    );

    function automatic logic [CH_W-1:0] lowest(input logic [NUM_CH-1:0] v);
        lowest = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) if (v[i]) lowest = CH_W'(i);
    endfunction

    function automatic logic [CNT_W-1:0] win_init(input logic [GRP_W-1:0] g);
        win_init = {1'b0, samp_time[g*SAMP_W +: SAMP_W]} + CNT_W'(1);
    endfunction

    always_comb begin
        logic [NUM_CH-1:0] nxt;
        s_d        = s_q;
        s_d.cstart = 1'b0;
        s_d.send   = '0;
        q_pop      = 1'b0;
        q_rq       = 1'b0;
        nxt        = '0;

        hw_eff   = {1'b1, hw_mode};
        cont_eff = cont_mode;
        if (&cont_mode) cont_eff[1] = 1'b0;

        for (int g = 0; g < NUM_GRP; g++) begin
            if (sel_wr[g]) s_d.mask[g] = sel_mask;
            accept[g] = enable && !s_q.busy[g] &&
                        ((!hw_eff[g] && sel_wr[g] && (|sel_mask)) ||
                         ( hw_eff[g] && edge_hit[g] && (|s_d.mask[g])));
            if (accept[g]) s_d.busy[g] = 1'b1;
        end

        unique case (s_q.st)
            ST_IDLE: begin
                if (enable && head_valid) begin
                    q_pop   = 1'b1;
                    s_d.grp = head_id;
                    s_d.rem = s_q.mask[head_id];
                    if (s_q.mask[head_id] == '0) begin
                        s_d.busy[head_id] = 1'b0;
                        s_d.send[head_id] = 1'b1;
                    end else begin
                        s_d.ch  = lowest(s_q.mask[head_id]);
                        s_d.cnt = win_init(head_id);
                        s_d.st  = ST_SAMPLE;
                    end
                end
            end
            ST_SAMPLE: begin
                if (s_q.cnt == '0) begin
                    s_d.st     = ST_CONVERT;
                    s_d.cstart = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_CONVERT: begin
                if (conv_done) begin
                    nxt = s_q.rem & ~(NUM_CH'(1) << s_q.ch);
                    if (nxt != '0) begin
                        s_d.rem = nxt;
                        s_d.ch  = lowest(nxt);
                        s_d.cnt = win_init(s_q.grp);
                        s_d.st  = ST_SAMPLE;
                    end else if (cont_eff[s_q.grp] && enable && (|s_q.mask[s_q.grp])) begin
                        if (head_valid) begin
                            q_rq   = 1'b1;
                            s_d.st = ST_IDLE;
                        end else begin
                            s_d.rem = s_q.mask[s_q.grp];
                            s_d.ch  = lowest(s_q.mask[s_q.grp]);
                            s_d.cnt = win_init(s_q.grp);
                            s_d.st  = ST_SAMPLE;
                        end
                    end else begin
                        s_d.busy[s_q.grp] = 1'b0;
                        s_d.send[s_q.grp] = 1'b1;
                        s_d.st            = ST_IDLE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_start = s_q.cstart;
    assign sampling   = (s_q.st == ST_SAMPLE);
    assign act_valid  = (s_q.st != ST_IDLE);
    assign act_grp    = s_q.grp;
    assign act_ch     = s_q.ch;
    assign busy       = s_q.busy;
    assign seq_end    = s_q.send;
endmodule

// File: rtl/adc_seq_sched_chk.sv
module adc_seq_sched_chk #(
    parameter int NUM_GRP = 3,
    parameter int GRP_W   = 2,
    parameter int CH_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               conv_done,
    input logic               conv_start,
    input logic               sampling,
    input logic               act_valid,
    input logic [GRP_W-1:0]   act_grp,
    input logic [CH_W-1:0]    act_ch,
    input logic [NUM_GRP-1:0] busy,
    input logic [NUM_GRP-1:0] seq_end
);
    logic pend_q;
    logic [NUM_GRP-1:0] grp_bit;

    assign grp_bit = NUM_GRP'(1) << act_grp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (conv_start) pend_q <= 1'b1;
        else if (conv_done)  pend_q <= 1'b0;
    end

    AST_STROBE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(sampling)); // R1
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R1
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !pend_q); // R2
    AST_WINDOW_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && $past(sampling)) |-> ($stable(act_ch) && $stable(act_grp))); // R2
    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_valid) |-> $past(enable)); // R5
    AST_ACTIVE_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> ((busy & grp_bit) != '0)); // R10
    AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end != '0) |-> ((seq_end & busy) == '0)); // R10
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && $past(act_valid) && !$past(conv_done)) |-> $stable(act_grp)); // R12
endmodule

bind adc_seq_sched adc_seq_sched_chk #(
    .NUM_GRP(adc_seq_pkg::NUM_GRP),
    .GRP_W  (adc_seq_pkg::GRP_W),
    .CH_W   ($clog2(NUM_CH))
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .sampling   (sampling),
    .act_valid  (act_valid),
    .act_grp    (act_grp),
    .act_ch     (act_ch),
    .busy       (busy),
    .seq_end    (seq_end)
);

// File: tb/test_adc_seq_sched.sv
module test_adc_seq_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  sel_wr = '0;
    logic [15:0] sel_mask = '0;
    logic [2:0]  cont_mode = '0;
    logic [1:0]  hw_mode = '0;
    logic [8:0]  trig_src = '0;
    logic [2:0]  trig_pol = '0;
    logic [35:0] samp_time = '0;
    logic [7:0]  evt_in = 8'hFF;
    logic        conv_done = 1'b0;
    logic        conv_start, sampling, act_valid;
    logic [1:0]  act_grp;
    logic [3:0]  act_ch;
    logic [2:0]  busy, seq_end;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int rec_grp [0:255];
    int rec_ch  [0:255];
    int rec_win [0:255];
    int rec_n = 0, win_run = 0, dn_wait = 0, end_cnt0 = 0, end_cnt1 = 0;
    bit dn_pend = 0;

    always #2 clk = ~clk;

    adc_seq_sched i_adc_seq_sched (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sel_wr(sel_wr), .sel_mask(sel_mask),
        .cont_mode(cont_mode), .hw_mode(hw_mode), .trig_src(trig_src), .trig_pol(trig_pol),
        .samp_time(samp_time), .evt_in(evt_in), .conv_done(conv_done),
        .conv_start(conv_start), .sampling(sampling), .act_valid(act_valid),
        .act_grp(act_grp), .act_ch(act_ch), .busy(busy), .seq_end(seq_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        popc = 0;
        for (int i = 0; i < 16; i++) popc += int'(m[i]);
    endfunction

    function automatic int nth_ch(input logic [15:0] m, input int k);
        int seen = 0;
        nth_ch = -1;
        for (int i = 0; i < 16; i++)
            if (m[i]) begin
                if (seen == k) nth_ch = i;
                seen++;
            end
    endfunction

    // converter model and recorder
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            conv_done = 1'b0;
            if (sampling) win_run++;
            if (seq_end[0]) end_cnt0++;
            if (seq_end[1]) end_cnt1++;
            if (dn_pend) begin
                if (dn_wait == 0) begin conv_done = 1'b1; dn_pend = 0; end
                else dn_wait--;
            end
            if (conv_start) begin
                if (rec_n < 256) begin
                    rec_grp[rec_n] = int'(act_grp);
                    rec_ch[rec_n]  = int'(act_ch);
                    rec_win[rec_n] = win_run;
                    rec_n++;
                end
                win_run = 0;
                dn_pend = 1;
                dn_wait = int'($urandom % 3);
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                chk(1'b0, "watchdog", cyc, 150000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    task automatic wr(input int g, input logic [15:0] m);
        @(negedge clk);
        sel_wr = 3'(1 << g);
        sel_mask = m;
        @(negedge clk);
        sel_wr = '0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        repeat (2) @(negedge clk);
        while ((busy != '0 || act_valid) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, req, t, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic clr();
        rec_n = 0; end_cnt0 = 0; end_cnt1 = 0;
    endtask

    initial begin
        logic [15:0] ma, mb, mf, ms;
        int sa, sb, sf, ss, gf, gs, j;
        void'($urandom(32'd4242));
        trig_src[8:6] = 3'd5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && !act_valid && !conv_start && seq_end == 0, "R10 reset idle", int'(busy), 0);
        enable = 1'b1;

        // R1 R2 R3 R10: random pairs of single sequences, ordered by write time (R4)
        for (int it = 0; it < 8; it++) begin
            ma = 16'($urandom) | 16'(1 << (it % 16));
            mb = 16'($urandom) | 16'h8000;
            sa = (it == 0) ? 0 : int'($urandom % 6);
            sb = int'($urandom % 6);
            samp_time[11:0] = 12'(sa);
            samp_time[23:12] = 12'(sb);
            gf = int'($urandom % 2); gs = 1 - gf;
            mf = gf == 0 ? ma : mb; ms = gf == 0 ? mb : ma;
            sf = gf == 0 ? sa : sb; ss = gf == 0 ? sb : sa;
            clr();
            wr(gf, mf);
            wr(gs, ms);
            wait_idle("R10 sequence ends");
            chk(rec_n == popc(mf) + popc(ms), "R2 conversion count", rec_n, popc(mf) + popc(ms));
            for (int k = 0; k < rec_n; k++) begin
                if (k < popc(mf)) begin
                    chk(rec_grp[k] == gf, "R4 group order", rec_grp[k], gf);
                    chk(rec_ch[k] == nth_ch(mf, k), "R2 ascending channel", rec_ch[k], nth_ch(mf, k));
                    chk(rec_win[k] == sf + 2, "R1 sample window", rec_win[k], sf + 2);
                end else begin
                    chk(rec_grp[k] == gs, "R4 group order", rec_grp[k], gs);
                    chk(rec_ch[k] == nth_ch(ms, k - popc(mf)), "R2 ascending channel", rec_ch[k], nth_ch(ms, k - popc(mf)));
                    chk(rec_win[k] == ss + 2, "R1 sample window", rec_win[k], ss + 2);
                end
            end
            chk(end_cnt0 == 1 && end_cnt1 == 1, "R10 one seq_end pulse each", end_cnt0 * 10 + end_cnt1, 11);
        end

        // R4: same-cycle triggers, lower index first
        samp_time[23:0] = '0;
        clr();
        @(negedge clk); sel_wr = 3'b011; sel_mask = 16'h0006;
        @(negedge clk); sel_wr = '0;
        wait_idle("R4 same cycle idle");
        chk(rec_n == 4 && rec_grp[0] == 0 && rec_grp[1] == 0 && rec_grp[2] == 1, "R4 same-cycle order", rec_grp[2], 1);

        // R3: zero mask write starts nothing
        clr();
        wr(0, 16'h0000);
        repeat (6) @(negedge clk);
        chk(busy == 0 && !act_valid && rec_n == 0, "R3 zero mask ignored", int'(busy), 0);

        // R5: trigger while disabled is dropped
        enable = 1'b0;
        wr(1, 16'h0010);
        repeat (6) @(negedge clk);
        chk(busy == 0 && !act_valid, "R5 disabled trigger ignored", int'(busy), 0);
        enable = 1'b1;
        repeat (8) @(negedge clk);
        chk(busy == 0 && rec_n == 0, "R5 dropped trigger stays lost", rec_n, 0);

        // R11: retrigger while running
        samp_time[11:0] = 12'd3;
        clr();
        wr(0, 16'h0003);
        repeat (3) @(negedge clk);
        wr(0, 16'h0003);
        wait_idle("R11 idle");
        chk(rec_n == 2, "R11 retrigger ignored", rec_n, 2);

        // R8: event group
        clr();
        wr(2, 16'h0030);
        repeat (6) @(negedge clk);
        chk(busy[2] == 0 && rec_n == 0, "R8 mask write does not start", rec_n, 0);
        evt_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy[2] == 0, "R8 other source ignored", int'(busy[2]), 0);
        evt_in[5] = 1'b0;
        wait_idle("R8 idle");
        chk(rec_n == 2 && rec_grp[0] == 2 && rec_ch[0] == 4 && rec_ch[1] == 5, "R8 falling edge starts", rec_n, 2);
        clr();
        evt_in[5] = 1'b1;
        repeat (6) @(negedge clk);
        chk(busy[2] == 0 && rec_n == 0, "R8 rising ignored with polarity 0", rec_n, 0);
        trig_pol[2] = 1'b1;
        evt_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        evt_in[5] = 1'b1;
        wait_idle("R8 rising idle");
        chk(rec_n == 2 && rec_grp[1] == 2, "R8 rising edge with polarity 1", rec_n, 2);

        // R9: general group in hardware mode
        clr();
        hw_mode[0] = 1'b1; trig_src[2:0] = 3'd2; trig_pol[0] = 1'b1;
        wr(0, 16'h0080);
        repeat (6) @(negedge clk);
        chk(busy[0] == 0 && rec_n == 0, "R9 write does not start hw group", rec_n, 0);
        evt_in[2] = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy[0] == 0, "R9 wrong edge ignored", int'(busy[0]), 0);
        evt_in[2] = 1'b1;
        wait_idle("R9 idle");
        chk(rec_n == 1 && rec_grp[0] == 0 && rec_ch[0] == 7, "R9 edge starts hw group", rec_ch[0], 7);
        hw_mode[0] = 1'b0;

        // R10 R7: continuous reload then graceful stop
        samp_time[11:0] = '0;
        clr();
        cont_mode[0] = 1'b1;
        wr(0, 16'h0005);
        while (rec_n < 5) @(negedge clk);
        cont_mode[0] = 1'b0;
        wait_idle("R7 idle");
        chk(rec_n >= 6 && rec_n % 2 == 0, "R7 finishes pass", rec_n % 2, 0);
        chk(rec_ch[2] == 0 && rec_ch[3] == 2, "R10 continuous reload", rec_ch[2], 0);
        chk(rec_ch[rec_n-1] == 2 && end_cnt0 == 1, "R7 stops after last channel", rec_ch[rec_n-1], 2);

        // R6: all three continuous, group 1 runs once
        clr();
        cont_mode = 3'b111;
        wr(1, 16'h0006);
        wait_idle("R6 idle");
        chk(rec_n == 2 && end_cnt1 == 1, "R6 group 1 forced single", rec_n, 2);
        cont_mode = '0;

        // R12: continuous group yields at pass end
        clr();
        cont_mode[0] = 1'b1;
        wr(0, 16'h0001);
        while (rec_n < 2) @(negedge clk);
        wr(1, 16'h0008);
        j = -1;
        while (j < 0) begin
            @(negedge clk);
            for (int k = 0; k < rec_n; k++) if (rec_grp[k] == 1 && j < 0) j = k;
        end
        cont_mode[0] = 1'b0;
        wait_idle("R12 idle");
        chk(rec_ch[j] == 3 && rec_n > j + 1, "R12 queued group served", rec_ch[j], 3);
        chk(rec_grp[j+1] == 0 && rec_grp[j-1] == 0, "R12 continuous group resumes", rec_grp[j+1], 0);

        // R1: longest window
        samp_time[23:12] = 12'd4095;
        clr();
        wr(1, 16'h0200);
        wait_idle("R1 long idle");
        chk(rec_n == 1 && rec_win[0] == 4097, "R1 maximum window", rec_win[0], 4097);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule